// File: doc/BRIEF.md
# DRAM Refresh Cycle Sequencer

This block generates the control strobes of an asynchronous DRAM for one refresh operation, chosen per request from three forms. In the row-address form it puts the next row on the address bus and pulses the row strobe with the column strobe held high. The row comes from an internal counter that wraps after the last row. In the counter form the column strobe falls before the row strobe, so the memory refreshes from its own row counter and no address is driven. A burst of such refreshes keeps the column strobe low and cycles only the row strobe. In the hidden form the block first performs a read (row, then column with output enable). It then precharges and re-lowers the row strobe with the column strobe and output enable still low, so read data stays on the bus during the refresh.

A scheduler outside the block decides when to refresh. It waits for `ready_o`, pulses `start_i` with a mode code and the timing values, and receives `done_o` when the strobes go back to the inactive level. Every timing value is a number of clock cycles, and a value of zero counts as one cycle. The mode code and timing values are captured when the request is accepted.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset all strobes (`row_strobe_n_o`, `col_strobe_n_o`, `out_en_n_o`, `wr_en_n_o`) are high, `addr_en_o` and `done_o` are low and `ready_o` is high.
- R2: Mode code 0 (row-address refresh): the address is driven with every strobe high for `cas_setup_i` cycles. `row_strobe_n_o` is then low for `ras_act_i` cycles with the address still driven. Column strobe and output enable stay high throughout.
- R3: The row driven in mode 0 is 0 for the first refresh after reset. It rises by one with each mode-0 refresh and wraps from ROWS-1 to 0.
- R4: Mode code 1, and the unused code 3 (counter refresh): the column strobe falls `cas_setup_i` cycles before the row strobe falls. Write enable stays high and no address is driven.
- R5: In counter and hidden refresh, each refresh low phase of the row strobe lasts the larger of `ras_act_i` and `cas_hold_i` cycles, with the column strobe low throughout.
- R6: A counter refresh performs `burst_i` refreshes (0 counts as 1). Between refreshes the row strobe is high for `ras_pre_i` cycles while the column strobe stays low.
- R7: Mode code 2 (hidden refresh): the read row is driven for `cas_setup_i` cycles, then held with the row strobe low for `cas_setup_i` cycles. The column address then follows with column strobe and output enable low for `ras_act_i` cycles. Next comes `ras_pre_i` cycles of row strobe high with column strobe and output enable kept low, then one refresh low phase as in R5.
- R8: `done_o` is high for exactly one cycle, the first cycle in which all strobes are high again. `ready_o` returns `ras_pre_i` cycles after that cycle began.
- R9: `ready_o` is high only while idle, and then no strobe is low and no address is driven. A start received while not ready changes neither the waveform nor the row counter.
- R10: A timing value or burst count of 0 behaves as 1.
- R11: Counter and hidden refreshes leave the internal row counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only while ready |
| kind_i | input | 2 | Mode: 0 row-address, 1 or 3 counter, 2 hidden after read |
| ras_act_i | input | CNT_W | Row strobe low width, cycles |
| ras_pre_i | input | CNT_W | Row strobe precharge width, cycles |
| cas_setup_i | input | CNT_W | Column-before-row setup, also address setup, cycles |
| cas_hold_i | input | CNT_W | Column strobe hold after row strobe falls, cycles |
| burst_i | input | CNT_W | Number of counter refreshes in one request |
| rd_row_i | input | ROW_W | Row of the read in hidden mode |
| rd_col_i | input | ROW_W | Column of the read in hidden mode |
| ready_o | output | 1 | Idle and able to accept a request |
| row_strobe_n_o | output | 1 | Row address strobe, active low |
| col_strobe_n_o | output | 1 | Column address strobe, active low |
| wr_en_n_o | output | 1 | Write enable, active low |
| out_en_n_o | output | 1 | Output enable, active low |
| addr_o | output | ROW_W | Multiplexed address bus |
| addr_en_o | output | 1 | Address bus driven |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The strobes are decoded directly from the sequencer state. A wrong state or a wrong segment length therefore appears in the strobe pattern in the same cycle it occurs, and the bench compares that pattern cycle by cycle against a trace it builds from the requirements. A wrong row counter stays hidden through counter and hidden refreshes and only appears on the address bus at the next row-address refresh. The sweep therefore interleaves the modes and runs past the counter wrap. A start accepted while busy shows up as a longer trace or a skipped row.

// File: rtl/dref_pkg.sv
package dref_pkg;
    // Refresh form selected per request
    typedef enum logic [1:0] {
        K_ROWADDR  = 2'd0,
        K_COUNTER  = 2'd1,
        K_READHIDE = 2'd2
    } kind_e;

    // Sequencer states; each non-idle state is one waveform segment
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_RROW, S_RCOL, S_CSU, S_ACT, S_PRE, S_REC
    } state_e;

    // Map the external mode code to a refresh form; the spare code acts as counter refresh
    function automatic kind_e decode_kind(input logic [1:0] code);
        case (code)
            2'd0:    return K_ROWADDR;
            2'd2:    return K_READHIDE;
            default: return K_COUNTER;
        endcase
    endfunction
endpackage

// File: rtl/dref_timer.sv
// Segment timer. A load of length L makes expire_o rise L cycles later
// (L of zero counts as one). Assumes the owner reloads on every segment entry.
module dref_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load length minus one, then count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/dref_row_ctr.sv
// Wrapping row counter for row-address refresh. Steps once per step_i pulse
// and wraps from ROWS-1 to zero. Assumes ROWS is at least 2.
module dref_row_ctr #(
    parameter int ROWS  = 2048,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    generate
        if ((1 << ROW_W) == ROWS) begin : g_pow2
            // Power-of-two row count: natural binary wrap
            always_ff @(posedge clk) begin
                if (!rst_n)      row_q <= '0;
                else if (step_i) row_q <= row_q + 1'b1;
            end
        end else begin : g_mod
            // Other row counts: explicit compare against the last row
            always_ff @(posedge clk) begin
                if (!rst_n)
                    row_q <= '0;
                else if (step_i)
                    row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
            end
        end
    endgenerate

    assign row_o = row_q;
endmodule

// File: rtl/dref_fsm.sv
// Refresh sequencer state machine. Captures mode and timing on an accepted
// start, steps through the segments of the chosen form, counts burst refreshes,
// and flags the first recovery cycle. Assumes a dref_timer driven by load_o/len_o.
module dref_fsm
    import dref_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       kind_i,
    input  logic [CNT_W-1:0] ras_act_i,
    input  logic [CNT_W-1:0] ras_pre_i,
    input  logic [CNT_W-1:0] cas_setup_i,
    input  logic [CNT_W-1:0] cas_hold_i,
    input  logic [CNT_W-1:0] burst_i,
    input  logic             expire_i,
    output logic             load_o,
    output logic [CNT_W-1:0] len_o,
    output state_e           state_o,
    output kind_e            kind_o,
    output logic             accept_o,
    output logic             row_step_o,
    output logic             done_o
);
    state_e           state_q, state_d;
    kind_e            kind_q;
    logic [CNT_W-1:0] act_q, pre_q, su_q, hold_q, left_q;
    logic             done_q, left_dec;
    logic [CNT_W-1:0] ref_len;

    // Treat a zero cycle count as one
    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

    assign accept_o = (state_q == S_IDLE) && start_i;

    // Refresh low phase covers both the strobe width and the column hold
    always_comb begin
        ref_len = (at_least_one(act_q) > at_least_one(hold_q)) ? at_least_one(act_q)
                                                              : at_least_one(hold_q);
    end

    // Next segment and timer length on each segment end
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        len_o      = '0;
        row_step_o = 1'b0;
        left_dec   = 1'b0;
        case (state_q)
            S_IDLE: if (start_i) begin
                load_o  = 1'b1;
                len_o   = cas_setup_i;
                state_d = (decode_kind(kind_i) == K_COUNTER) ? S_CSU : S_ADDR;
            end
            S_ADDR: if (expire_i) begin
                load_o = 1'b1;
                if (kind_q == K_ROWADDR) begin
                    state_d = S_ACT;
                    len_o   = act_q;
                end else begin
                    state_d = S_RROW;
                    len_o   = su_q;
                end
            end
            S_RROW: if (expire_i) begin
                load_o  = 1'b1;
                len_o   = act_q;
                state_d = S_RCOL;
            end
            S_RCOL: if (expire_i) begin
                load_o  = 1'b1;
                len_o   = pre_q;
                state_d = S_PRE;
            end
            S_CSU: if (expire_i) begin
                load_o  = 1'b1;
                len_o   = ref_len;
                state_d = S_ACT;
            end
            S_ACT: if (expire_i) begin
                load_o = 1'b1;
                len_o  = pre_q;
                if (kind_q == K_ROWADDR) begin
                    row_step_o = 1'b1;
                    state_d    = S_REC;
                end else if (kind_q == K_COUNTER && left_q > CNT_W'(1)) begin
                    left_dec = 1'b1;
                    state_d  = S_PRE;
                end else begin
                    state_d = S_REC;
                end
            end
            S_PRE: if (expire_i) begin
                load_o  = 1'b1;
                len_o   = ref_len;
                state_d = S_ACT;
            end
            S_REC: if (expire_i) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and done flag for the first recovery cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_d == S_REC) && (state_q != S_REC);
        end
    end

    // Capture the request and count down the remaining burst refreshes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_ROWADDR;
            act_q  <= '0;
            pre_q  <= '0;
            su_q   <= '0;
            hold_q <= '0;
            left_q <= '0;
        end else if (accept_o) begin
            kind_q <= decode_kind(kind_i);
            act_q  <= ras_act_i;
            pre_q  <= ras_pre_i;
            su_q   <= cas_setup_i;
            hold_q <= cas_hold_i;
            left_q <= at_least_one(burst_i);
        end else if (left_dec) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign state_o = state_q;
    assign kind_o  = kind_q;
    assign done_o  = done_q;
endmodule

// File: rtl/dref_drive.sv
// Strobe and address decode. Turns the sequencer state and refresh form into
// the DRAM control levels and the multiplexed address. Captures the read
// address when a request is accepted. Assumes state changes only on clock edges.
module dref_drive
    import dref_pkg::*;
#(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic [ROW_W-1:0] rd_row_i,
    input  logic [ROW_W-1:0] rd_col_i,
    input  state_e           state_i,
    input  kind_e            kind_i,
    input  logic [ROW_W-1:0] ctr_row_i,
    output logic             row_n_o,
    output logic             col_n_o,
    output logic             oe_n_o,
    output logic             aen_o,
    output logic [ROW_W-1:0] addr_o
);
    logic [ROW_W-1:0] rrow_q, rcol_q;
    logic             hide;

    // Hold the read address steady for the whole request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrow_q <= '0;
            rcol_q <= '0;
        end else if (accept_i) begin
            rrow_q <= rd_row_i;
            rcol_q <= rd_col_i;
        end
    end

    assign hide = (kind_i == K_READHIDE);

    // Decode the control levels of each segment
    always_comb begin
        row_n_o = 1'b1;
        col_n_o = 1'b1;
        oe_n_o  = 1'b1;
        aen_o   = 1'b0;
        addr_o  = '0;
        case (state_i)
            S_ADDR: begin
                aen_o  = 1'b1;
                addr_o = hide ? rrow_q : ctr_row_i;
            end
            S_RROW: begin
                row_n_o = 1'b0;
                aen_o   = 1'b1;
                addr_o  = rrow_q;
            end
            S_RCOL: begin
                row_n_o = 1'b0;
                col_n_o = 1'b0;
                oe_n_o  = 1'b0;
                aen_o   = 1'b1;
                addr_o  = rcol_q;
            end
            S_CSU: col_n_o = 1'b0;
            S_ACT: begin
                row_n_o = 1'b0;
                if (kind_i == K_ROWADDR) begin
                    aen_o  = 1'b1;
                    addr_o = ctr_row_i;
                end else begin
                    col_n_o = 1'b0;
                    oe_n_o  = !hide;
                end
            end
            S_PRE: begin
                col_n_o = 1'b0;
                oe_n_o  = !hide;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_refresh_seq.sv
// DRAM refresh cycle sequencer top. Runs one row-address, counter or hidden
// refresh per accepted start. Assumes timing inputs count clock cycles and that
// a scheduler elsewhere decides when to refresh.
module dram_refresh_seq #(
    parameter int ROWS  = 2048,
    parameter int CNT_W = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       kind_i,
    input  logic [CNT_W-1:0] ras_act_i,
    input  logic [CNT_W-1:0] ras_pre_i,
    input  logic [CNT_W-1:0] cas_setup_i,
    input  logic [CNT_W-1:0] cas_hold_i,
    input  logic [CNT_W-1:0] burst_i,
    input  logic [ROW_W-1:0] rd_row_i,
    input  logic [ROW_W-1:0] rd_col_i,
    output logic             ready_o,
    output logic             row_strobe_n_o,
    output logic             col_strobe_n_o,
    output logic             wr_en_n_o,
    output logic             out_en_n_o,
    output logic [ROW_W-1:0] addr_o,
    output logic             addr_en_o,
    output logic             done_o
);
    import dref_pkg::*;

    logic             load, expire, accept, step;
    logic [CNT_W-1:0] len;
    logic [ROW_W-1:0] ctr_row;
    state_e           state;
    kind_e            kind;

    dref_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(len), .expire_o(expire)
    );

    dref_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .ras_act_i(ras_act_i), .ras_pre_i(ras_pre_i), .cas_setup_i(cas_setup_i),
        .cas_hold_i(cas_hold_i), .burst_i(burst_i), .expire_i(expire),
        .load_o(load), .len_o(len), .state_o(state), .kind_o(kind),
        .accept_o(accept), .row_step_o(step), .done_o(done_o)
    );

    dref_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .step_i(step), .row_o(ctr_row)
    );

    dref_drive #(.ROW_W(ROW_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .rd_row_i(rd_row_i),
        .rd_col_i(rd_col_i), .state_i(state), .kind_i(kind), .ctr_row_i(ctr_row),
        .row_n_o(row_strobe_n_o), .col_n_o(col_strobe_n_o), .oe_n_o(out_en_n_o),
        .aen_o(addr_en_o), .addr_o(addr_o)
    );

    // Only refresh and read cycles are produced, so writes never occur
    assign wr_en_n_o = 1'b1;
    assign ready_o   = (state == S_IDLE);
endmodule

// File: rtl/dref_seq_chk.sv
// Port-level protocol checker for dram_refresh_seq, attached by bind.
module dref_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic ready,
    input logic row_n,
    input logic col_n,
    input logic oe_n,
    input logic we_n,
    input logic aen,
    input logic done
);
    // R4: a row strobe fall with column strobe low had column strobe low the cycle before
    a_r4_col_leads_row: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_n) && !col_n) |-> ($past(col_n) == 1'b0));

    // R2: a row strobe fall with column strobe high has the address driven before and at it
    a_r2_addr_before_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(row_n) && col_n) |-> (aen && $past(aen)));

    // R5: column strobe low without output enable is a counter refresh: no address
    a_r5_no_addr_counter: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_n && oe_n) |-> !aen);

    // R8: done is a single cycle and coincides with all strobes high
    a_r8_done_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (row_n && col_n && oe_n && we_n && !aen && !$past(done)));

    // R9: ready only with the bus quiet
    a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (row_n && col_n && oe_n && !aen && !done));

    // R7: output enable only ever accompanies column strobe low
    a_r7_oe_with_col: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !col_n);
endmodule

bind dram_refresh_seq dref_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready_o), .row_n(row_strobe_n_o),
    .col_n(col_strobe_n_o), .oe_n(out_en_n_o), .we_n(wr_en_n_o),
    .aen(addr_en_o), .done(done_o)
);

// File: tb/sim_dram_refresh_seq.sv
module sim_dram_refresh_seq;
    localparam int ROWS = 8;
    localparam int RW   = 3;
    localparam int CW   = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [1:0] kind = 2'd0;
    logic [CW-1:0] act = '0, pre = '0, su = '0, hold = '0, burst = '0;
    logic [RW-1:0] rrow = '0, rcol = '0;
    logic ready, row_n, col_n, we_n, oe_n, aen, done;
    logic [RW-1:0] addr;

    dram_refresh_seq #(.ROWS(ROWS), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .kind_i(kind),
        .ras_act_i(act), .ras_pre_i(pre), .cas_setup_i(su), .cas_hold_i(hold),
        .burst_i(burst), .rd_row_i(rrow), .rd_col_i(rcol), .ready_o(ready),
        .row_strobe_n_o(row_n), .col_strobe_n_o(col_n), .wr_en_n_o(we_n),
        .out_en_n_o(oe_n), .addr_o(addr), .addr_en_o(aen), .done_o(done)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    logic [3:0]    ev [0:127];
    logic [RW-1:0] ea [0:127];
    int elen, erec;
    logic [RW-1:0] exp_row = '0;

    function automatic int e1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    // Append n cycles of {row_n,col_n,oe_n,aen} = c with address a
    task automatic add(input logic [3:0] c, input logic [RW-1:0] a, input int n);
        for (int k = 0; k < n; k++) begin
            ev[elen] = c;
            ea[elen] = a;
            elen++;
        end
    endtask

    // One request: build expected trace from the requirements, then compare
    task automatic run(input int k, input int s, input int w, input int p, input int h,
                       input int n, input bit poke, input string tag);
        int r, bad_at, abad_at, done_n, done_at, rdy_bad;
        logic [3:0] obs, bad_obs;
        r    = (e1(w) > e1(h)) ? e1(w) : e1(h);
        elen = 0;
        if (k == 0) begin
            add(4'b1111, exp_row, e1(s));
            add(4'b0111, exp_row, e1(w));
        end else if (k == 2) begin
            add(4'b1111, rrow, e1(s));
            add(4'b0111, rrow, e1(s));
            add(4'b0001, rcol, e1(w));
            add(4'b1000, '0, e1(p));
            add(4'b0000, '0, r);
        end else begin
            add(4'b1010, '0, e1(s));
            for (int j = 0; j < e1(n); j++) begin
                add(4'b0010, '0, r);
                if (j < e1(n) - 1) add(4'b1010, '0, e1(p));
            end
        end
        erec = elen;
        add(4'b1110, '0, e1(p));

        @(negedge clk);
        kind = 2'(k); su = CW'(s); act = CW'(w); pre = CW'(p); hold = CW'(h);
        burst = CW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad_at = -1; abad_at = -1; done_n = 0; done_at = -1; rdy_bad = 0; bad_obs = '0;
        for (int i = 0; i <= elen; i++) begin
            obs = {row_n, col_n, oe_n, aen};
            if (i < elen) begin
                if (obs != ev[i] && bad_at < 0) begin bad_at = i; bad_obs = obs; end
                if (ev[i][0] && addr != ea[i] && abad_at < 0) abad_at = i;
                if (ready) rdy_bad++;
            end else begin
                if (obs != 4'b1110 || !ready) rdy_bad++;
            end
            if (done) begin done_n++; done_at = i; end
            if (!we_n) rdy_bad++;
            if (poke && i == 1) begin start = 1'b1; kind = 2'((k + 1) % 3); end
            if (poke && i == 2) start = 1'b0;
            @(negedge clk);
        end
        check(bad_at < 0, tag, "strobe trace {row,col,oe,aen} at first mismatch",
              bad_obs, (bad_at < 0) ? 0 : ev[bad_at]);
        check(abad_at < 0, (k == 0) ? "R3" : "R7", "address mismatch cycle", abad_at, -1);
        check(done_n == 1 && done_at == erec, "R8", "done pulse cycle", done_at, erec);
        check(rdy_bad == 0, "R9", "ready/write-enable violations", rdy_bad, 0);
        if (k == 0) exp_row = exp_row + 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(ready && row_n && col_n && oe_n && we_n && !aen && !done, "R1",
              "reset outputs {rdy,row,col,oe,we,aen,done}",
              {ready, row_n, col_n, oe_n, we_n, aen, done}, 7'b1111100);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && row_n && col_n && !aen, "R1", "idle after reset", ready, 1);
        rrow = 3'd5; rcol = 3'd2;

        // R2 R3: row-address sweep (12 runs cover the wrap at ROWS-1)
        for (int s = 0; s <= 2; s++)
            for (int w = 1; w <= 3; w += 2)
                for (int p = 1; p <= 2; p++)
                    run(0, s, w, p, 0, 0, 1'b0, "R2");
        // R4 R5 R6: counter refresh sweep with bursts
        for (int s = 1; s <= 2; s++)
            for (int w = 1; w <= 3; w += 2)
                for (int h = 0; h <= 4; h += 4)
                    for (int n = 1; n <= 3; n += 2)
                        run(1, s, w, 2, h, n, 1'b0, "R6");
        run(3, 2, 2, 1, 3, 2, 1'b0, "R4");
        // R11: row counter unchanged by counter refreshes above
        run(0, 1, 2, 1, 0, 0, 1'b0, "R11");
        // R7: hidden refresh sweep
        for (int s = 1; s <= 2; s++)
            for (int w = 1; w <= 3; w += 2)
                for (int p = 1; p <= 2; p++) begin
                    rrow = 3'(s + w); rcol = 3'(p + 4);
                    run(2, s, w, p, 2, 0, 1'b0, "R7");
                end
        run(0, 2, 1, 1, 0, 0, 1'b0, "R11");
        // R10: zero timing values and zero burst act as one
        run(1, 0, 0, 0, 0, 0, 1'b0, "R10");
        run(2, 0, 0, 0, 0, 0, 1'b0, "R10");
        run(0, 0, 0, 0, 0, 0, 1'b0, "R10");
        // R9: start while busy is ignored
        run(0, 2, 3, 2, 0, 0, 1'b1, "R9");
        run(1, 2, 2, 1, 1, 3, 1'b1, "R9");
        run(2, 1, 2, 1, 1, 0, 1'b1, "R9");
        run(0, 1, 1, 1, 0, 0, 1'b0, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule